// File: doc/BRIEF.md
# Set-Associative Translation Buffer

This block caches page table entries inside a memory management unit so that most virtual addresses are translated without a trip to memory. A requester presents a virtual address. The block splits it into a page offset, a set index and a tag. It compares the tag against every way of the indexed set and, one cycle later, reports a hit with the physical address and access permissions, or a miss. On a miss, an outside walker fetches the entry and writes it back through the fill port.

The default configuration uses 32-bit virtual and physical addresses, 4 KB pages, 4 sets and 2 ways. Each line holds a valid flag, a tag, a physical page number and four permission flags. A fill goes to the way that already holds the same tag if there is one. Otherwise it goes to the lowest-numbered empty way, and otherwise to the least recently used way of the set. A flush input empties the whole buffer in one cycle.

Top module: `translation_buffer`

## Requirements
- R1: After reset every entry is invalid, all response outputs are zero, and the first lookup to any address misses.
- R2: A lookup request produces `rsp_valid` high in exactly the next cycle. `rsp_valid` is low in any cycle that follows a cycle with no request.
- R3: The address is split into offset bits [11:0], set index bits [13:12] and tag bits [31:14]. A hit needs a valid way in the indexed set whose stored tag equals the tag bits. On a hit, `rsp_paddr` is the stored 20-bit page number followed by the unchanged offset. `rsp_perm` returns the stored flags as bit 3 execute, bit 2 user, bit 1 read and bit 0 write.
- R4: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, and both `rsp_paddr` and `rsp_perm` are zero. Exactly one of `rsp_hit` and `rsp_miss` is high while `rsp_valid` is high.
- R5: Sets are independent. A tag stored in one set does not hit when the same tag is looked up with a different index.
- R6: A fill whose tag is absent from the set writes the lowest-numbered invalid way when one exists. The entry is valid from the next cycle on.
- R7: When the set is full, a fill replaces the least recently used way. Both a lookup hit and a fill count as a use of that way.
- R8: A fill whose tag is already valid in the set overwrites that way, so the set never holds two valid copies of one tag.
- R9: A flush invalidates every entry in one cycle. A lookup in the same cycle as a flush reports a miss.
- R10: A fill in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The filled entry is visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Write an entry |
| fill_vaddr | input | 32 | Virtual address whose page the entry maps |
| fill_ppn | input | 20 | Physical page number to store |
| fill_perm | input | 4 | Permission flags to store (execute, user, read, write) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; entry must be fetched |
| rsp_paddr | output | 32 | Physical address on a hit, zero otherwise |
| rsp_perm | output | 4 | Permission flags on a hit, zero otherwise |

## Verification
Every lookup result is due at the output register one clock edge after the request is driven. Fill and flush effects are due from the edge that takes them, so they become visible to a lookup driven in the following cycle. The bench drives inputs on the falling edge, then reads the response on the next falling edge, which is a full cycle later and past exactly one rising edge. It holds a reference table updated in request order, with the lookup applied before any same-cycle fill. This makes the expected hit, address and flags arithmetic for every case: full sweeps, replacement, duplicates and same-cycle collisions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // permission flags held per entry; bit order is observable on rsp_perm
   typedef struct packed {
      logic exec;
      logic user;
      logic rd;
      logic wr;
   } tlb_perm_t;

   localparam int PERM_W = $bits(tlb_perm_t);
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int SET_W  = 2,
   parameter int WAYS   = 2,
   parameter int WAY_W  = 1,
   parameter int TAG_W  = 18,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          wr_en,
   input  logic [SET_W-1:0]              wr_set,
   input  logic [WAY_W-1:0]              wr_way,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [PPN_W-1:0]              wr_ppn,
   input  logic [PERM_W-1:0]             wr_perm,
   input  logic [SET_W-1:0]              lk_set,
   output logic [WAYS-1:0]               lk_vld,
   output logic [WAYS-1:0][TAG_W-1:0]    lk_tag,
   output logic [WAYS-1:0][PPN_W-1:0]    lk_ppn,
   output logic [WAYS-1:0][PERM_W-1:0]   lk_perm,
   input  logic [SET_W-1:0]              fl_set,
   output logic [WAYS-1:0]               fl_vld,
   output logic [WAYS-1:0][TAG_W-1:0]    fl_tag
);
   localparam int SETS = 1 << SET_W;

   logic [SETS-1:0][WAYS-1:0] vld_q;
   logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
   logic [PPN_W-1:0]          ppn_q  [SETS][WAYS];
   logic [PERM_W-1:0]         perm_q [SETS][WAYS];

   logic commit;
   assign commit = wr_en && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set][wr_way] <= 1'b1;
      end
   end

   // payload carries no reset: valid bits guard every read
   always_ff @(posedge clk) begin
      if (commit) begin
         tag_q[wr_set][wr_way]  <= wr_tag;
         ppn_q[wr_set][wr_way]  <= wr_ppn;
         perm_q[wr_set][wr_way] <= wr_perm;
      end
   end

   assign lk_vld = vld_q[lk_set];
   assign fl_vld = vld_q[fl_set];

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign lk_tag[w]  = tag_q[lk_set][w];
      assign lk_ppn[w]  = ppn_q[lk_set][w];
      assign lk_perm[w] = perm_q[lk_set][w];
      assign fl_tag[w]  = tag_q[fl_set][w];
   end

   p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));

   p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> vld_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int WAYS   = 2,
   parameter int WAY_W  = 1,
   parameter int TAG_W  = 18,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   input  logic [WAYS-1:0]               vld,
   input  logic [WAYS-1:0][TAG_W-1:0]    tag,
   input  logic [WAYS-1:0][PPN_W-1:0]    ppn,
   input  logic [WAYS-1:0][PERM_W-1:0]   perm,
   input  logic [TAG_W-1:0]              key,
   output logic                          hit,
   output logic [WAY_W-1:0]              hit_way,
   output logic [PPN_W-1:0]              out_ppn,
   output logic [PERM_W-1:0]             out_perm
);
   logic [WAYS-1:0] hit_oh;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_oh[w] = en && vld[w] && (tag[w] == key);
   end

   // AND-OR selection: at most one way matches, so the OR is the pick
   always_comb begin
      out_ppn  = '0;
      out_perm = '0;
      hit_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_oh[w]) begin
            out_ppn  = out_ppn  | ppn[w];
            out_perm = out_perm | perm[w];
            hit_way  = hit_way  | WAY_W'(w);
         end
      end
   end

   assign hit = |hit_oh;

   p_one_way_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_oh));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int SET_W = 2,
   parameter int WAYS  = 2,
   parameter int WAY_W = 1,
   parameter int TAG_W = 18
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        fill_en,
   input  logic [SET_W-1:0]            fill_set,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic [WAYS-1:0]             set_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
   input  logic                        touch_en,
   input  logic [SET_W-1:0]            touch_set,
   input  logic [WAY_W-1:0]            touch_way,
   output logic [WAY_W-1:0]            victim_way
);
   localparam int SETS = 1 << SET_W;

   logic [WAYS-1:0]  dup_oh;
   logic             dup_hit;
   logic [WAY_W-1:0] dup_way;
   logic             free_any;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] repl_way;
   logic             commit;

   assign commit = fill_en && !flush;

   for (genvar w = 0; w < WAYS; w++) begin : g_dup
      assign dup_oh[w] = set_vld[w] && (set_tag[w] == fill_tag);
   end

   always_comb begin
      dup_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (dup_oh[w]) dup_way = dup_way | WAY_W'(w);
      end
   end

   // scan downward so the lowest empty way is the last one written
   always_comb begin
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!set_vld[w]) free_way = WAY_W'(w);
      end
   end

   assign dup_hit  = |dup_oh;
   assign free_any = ~&set_vld;

   assign victim_way = dup_hit  ? dup_way  :
                       free_any ? free_way : repl_way;

   if (WAYS == 2) begin : g_lru
      // one bit per set naming the way used least recently
      logic [SETS-1:0] lru_q;

      assign repl_way = lru_q[fill_set];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lru_q <= '0;
         end else begin
            if (touch_en) lru_q[touch_set] <= ~touch_way[0];
            if (commit)   lru_q[fill_set]  <= ~victim_way[0];
         end
      end
   end else begin : g_rr
      // wider sets fall back to a per-set rotating pointer
      logic [WAY_W-1:0] rr_q [SETS];

      assign repl_way = rr_q[fill_set];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
         end else if (commit && !dup_hit && !free_any) begin
            rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
         end
      end
   end

   p_free_way_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !dup_hit && free_any) |-> !set_vld[victim_way]);

   p_dup_reused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && dup_hit) |-> (set_vld[victim_way] && set_tag[victim_way] == fill_tag));
endmodule

// File: rtl/translation_buffer.sv
module translation_buffer
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int SET_W     = 2,
   parameter int WAYS      = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lk_valid,
   input  logic [VA_W-1:0]           lk_vaddr,
   input  logic                      flush,
   input  logic                      fill_valid,
   input  logic [VA_W-1:0]           fill_vaddr,
   input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input  logic [PERM_W-1:0]         fill_perm,
   output logic                      rsp_valid,
   output logic                      rsp_hit,
   output logic                      rsp_miss,
   output logic [PA_W-1:0]           rsp_paddr,
   output logic [PERM_W-1:0]         rsp_perm
);
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int TAG_W = VA_W - PAGE_BITS - SET_W;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int TAG_LO = PAGE_BITS + SET_W;

   if (TAG_W < 1) begin : g_bad_split
      $error("address too narrow for page and set fields");
   end
   if (PPN_W < 1) begin : g_bad_pa
      $error("physical address narrower than a page");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("way count must be a power of two, at least 2");
   end
   if (SET_W < 1) begin : g_bad_sets
      $error("at least two sets required");
   end

   // address fields
   logic [PAGE_BITS-1:0] lk_off;
   logic [SET_W-1:0]     lk_set, fl_set;
   logic [TAG_W-1:0]     lk_tag, fl_tag;

   assign lk_off = lk_vaddr[PAGE_BITS-1:0];
   assign lk_set = lk_vaddr[TAG_LO-1:PAGE_BITS];
   assign lk_tag = lk_vaddr[VA_W-1:TAG_LO];
   assign fl_set = fill_vaddr[TAG_LO-1:PAGE_BITS];
   assign fl_tag = fill_vaddr[VA_W-1:TAG_LO];

   logic [WAYS-1:0]              rd_vld, fs_vld;
   logic [WAYS-1:0][TAG_W-1:0]   rd_tag, fs_tag;
   logic [WAYS-1:0][PPN_W-1:0]   rd_ppn;
   logic [WAYS-1:0][PERM_W-1:0]  rd_perm;
   logic [WAY_W-1:0]             victim_way, hit_way;
   logic                         hit;
   logic [PPN_W-1:0]             hit_ppn;
   logic [PERM_W-1:0]            hit_perm;
   logic                         lk_live;

   // a flush in the same cycle forces the lookup to miss
   assign lk_live = lk_valid && !flush;

   tlb_store #(
      .SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W),
      .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (fill_valid),
      .wr_set  (fl_set),
      .wr_way  (victim_way),
      .wr_tag  (fl_tag),
      .wr_ppn  (fill_ppn),
      .wr_perm (fill_perm),
      .lk_set  (lk_set),
      .lk_vld  (rd_vld),
      .lk_tag  (rd_tag),
      .lk_ppn  (rd_ppn),
      .lk_perm (rd_perm),
      .fl_set  (fl_set),
      .fl_vld  (fs_vld),
      .fl_tag  (fs_tag)
   );

   tlb_match #(
      .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W),
      .PPN_W(PPN_W), .PERM_W(PERM_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (lk_live),
      .vld      (rd_vld),
      .tag      (rd_tag),
      .ppn      (rd_ppn),
      .perm     (rd_perm),
      .key      (lk_tag),
      .hit      (hit),
      .hit_way  (hit_way),
      .out_ppn  (hit_ppn),
      .out_perm (hit_perm)
   );

   tlb_victim #(
      .SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
   ) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fill_en    (fill_valid),
      .fill_set   (fl_set),
      .fill_tag   (fl_tag),
      .set_vld    (fs_vld),
      .set_tag    (fs_tag),
      .touch_en   (hit),
      .touch_set  (lk_set),
      .touch_way  (hit_way),
      .victim_way (victim_way)
   );

   // response register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_paddr <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= hit;
         rsp_miss  <= lk_valid && !hit;
         rsp_paddr <= hit ? {hit_ppn, lk_off} : '0;
         rsp_perm  <= hit ? hit_perm : '0;
      end
   end

   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit ^ rsp_miss));

   p_miss_zeroed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0 && rsp_perm == '0));

   p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));

   p_flush_lookup_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lk_valid) |=> rsp_miss);
endmodule

// File: tb/tb_translation_buffer.sv
module tb_translation_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        flush = 1'b0;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_vaddr = '0;
   logic [19:0] fill_ppn = '0;
   logic [3:0]  fill_perm = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [31:0] rsp_paddr;
   logic [3:0]  rsp_perm;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   translation_buffer dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .flush(flush),
      .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
      .fill_ppn(fill_ppn), .fill_perm(fill_perm),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
   );

   // reference table: 4 sets x 2 ways, tag = va[31:14], set = va[13:12]
   bit        mv [4][2];
   bit [17:0] mt [4][2];
   bit [19:0] mp [4][2];
   bit [3:0]  mm [4][2];
   bit        mlru [4];

   function automatic logic [31:0] mkva(input logic [17:0] t, input logic [1:0] s,
                                        input logic [11:0] o);
      return {t, s, o};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp_v);
      end
   endtask

   task automatic m_lookup(input logic [31:0] va, output bit h,
                           output logic [19:0] p, output logic [3:0] pm);
      int s = int'(va[13:12]);
      h = 0; p = '0; pm = '0;
      for (int w = 0; w < 2; w++) begin
         if (mv[s][w] && mt[s][w] == va[31:14]) begin
            h = 1; p = mp[s][w]; pm = mm[s][w];
            mlru[s] = (w == 0);
         end
      end
   endtask

   task automatic m_fill(input logic [31:0] va, input logic [19:0] p, input logic [3:0] pm);
      int s = int'(va[13:12]);
      int w = -1;
      for (int k = 0; k < 2; k++) if (mv[s][k] && mt[s][k] == va[31:14]) w = k;
      if (w < 0) begin
         if (!mv[s][0]) w = 0;
         else if (!mv[s][1]) w = 1;
         else w = int'(mlru[s]);
      end
      mv[s][w] = 1; mt[s][w] = va[31:14]; mp[s][w] = p; mm[s][w] = pm;
      mlru[s] = (w == 0);
   endtask

   task automatic m_flush();
      for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) mv[s][w] = 0;
   endtask

   // drive one cycle at a falling edge; check the response one edge later
   task automatic cyc(input bit lk, input logic [31:0] lva, input bit fl, input bit fv,
                      input logic [31:0] fva, input logic [19:0] fppn,
                      input logic [3:0] fpm, input string req);
      bit          eh = 0;
      logic [19:0] ep = '0;
      logic [3:0]  epm = '0;
      logic [38:0] ev, av;
      lk_valid = lk; lk_vaddr = lva; flush = fl;
      fill_valid = fv; fill_vaddr = fva; fill_ppn = fppn; fill_perm = fpm;
      if (lk && !fl) m_lookup(lva, eh, ep, epm);
      if (fl) m_flush();
      else if (fv) m_fill(fva, fppn, fpm);
      @(negedge clk);
      lk_valid = 0; flush = 0; fill_valid = 0;
      if (lk) begin
         ev = {1'b1, eh, !eh, eh ? epm : 4'h0, eh ? {ep, lva[11:0]} : 32'h0};
         av = {rsp_valid, rsp_hit, rsp_miss, rsp_perm, rsp_paddr};
         check(req, 64'(av), 64'(ev));
      end
   endtask

   task automatic look(input logic [31:0] va, input string req);
      cyc(1, va, 0, 0, '0, '0, '0, req);
   endtask

   task automatic fill(input logic [31:0] va, input logic [19:0] p, input logic [3:0] pm,
                       input string req);
      cyc(0, '0, 0, 1, va, p, pm, req);
   endtask

   // expected hit, stated directly rather than from the table
   task automatic expect_hit(input bit want, input string req);
      check(req, 64'(rsp_hit), 64'(want));
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         mlru[s] = 0;
         for (int w = 0; w < 2; w++) mv[s][w] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset outputs", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_perm, rsp_paddr}), 64'(0));
      for (int s = 0; s < 4; s++) begin
         look(mkva(18'h3, 2'(s), 12'h5a5), "R1 empty lookup");
         expect_hit(0, "R4 miss after reset");
      end
      // R2: no request, no response
      @(negedge clk);
      check("R2 idle rsp_valid", 64'(rsp_valid), 64'(0));

      // R6: fill every way of every set
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 2; w++)
            fill(mkva(18'(12'h100 + s * 2 + w), 2'(s), 12'h0),
                 20'hA0000 ^ 20'(s * 16 + w * 3 + 1), 4'(s * 2 + w + 5), "R6");

      // R3: hit sweep over every entry and several offsets
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 2; w++)
            for (int k = 0; k < 3; k++) begin
               logic [11:0] o = (k == 0) ? 12'h000 : (k == 1) ? 12'hfff : 12'h5a5;
               look(mkva(18'(12'h100 + s * 2 + w), 2'(s), o), "R3 hit sweep");
               expect_hit(1, "R3 stored entry hits");
            end

      // R5: tag of one set looked up in the neighbouring set
      for (int s = 0; s < 4; s++) begin
         look(mkva(18'(12'h100 + s * 2), 2'((s + 1) % 4), 12'h123), "R5 cross-set");
         expect_hit(0, "R5 cross-set misses");
      end

      // R7: set 2 holds tags 0x104 and 0x105; touch 0x104, fill new tag
      look(mkva(18'h104, 2'd2, 12'h010), "R7 touch");
      fill(mkva(18'h1f0, 2'd2, 12'h0), 20'h12345, 4'b1010, "R7 fill full set");
      look(mkva(18'h105, 2'd2, 12'h020), "R7 lru evicted");
      expect_hit(0, "R7 least recent way replaced");
      look(mkva(18'h104, 2'd2, 12'h030), "R7 recent kept");
      expect_hit(1, "R7 recent way kept");
      look(mkva(18'h1f0, 2'd2, 12'h040), "R7 new entry");

      // R8: refill 0x104 with a new mapping, then one more new tag
      fill(mkva(18'h104, 2'd2, 12'h0), 20'h0beef, 4'b0111, "R8 dup fill");
      look(mkva(18'h104, 2'd2, 12'h777), "R8 overwritten mapping");
      fill(mkva(18'h1f1, 2'd2, 12'h0), 20'h0cafe, 4'b1100, "R8 follow fill");
      look(mkva(18'h104, 2'd2, 12'h001), "R8 no duplicate");
      expect_hit(1, "R8 refreshed tag survives");
      look(mkva(18'h1f0, 2'd2, 12'h002), "R8 lru gone");
      expect_hit(0, "R8 other way replaced");
      look(mkva(18'h1f1, 2'd2, 12'h003), "R8 newest");

      // R11: lookup and fill of the same page in one cycle (set 3 tag 0x2aa)
      cyc(1, mkva(18'h2aa, 2'd3, 12'h444), 0, 1, mkva(18'h2aa, 2'd3, 12'h0),
          20'h55555, 4'b1001, "R11 same-cycle fill");
      expect_hit(0, "R11 old contents seen");
      look(mkva(18'h2aa, 2'd3, 12'h445), "R11 visible next cycle");
      expect_hit(1, "R11 fill visible");

      // R9: flush together with a lookup that would hit
      cyc(1, mkva(18'h2aa, 2'd3, 12'h446), 1, 0, '0, '0, '0, "R9 flush lookup");
      expect_hit(0, "R9 flush forces miss");
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 2; w++) begin
            look(mkva(18'(12'h100 + s * 2 + w), 2'(s), 12'h0aa), "R9 after flush");
            expect_hit(0, "R9 all entries cleared");
         end

      // R10: fill in a flush cycle is dropped
      fill(mkva(18'h3c3, 2'd1, 12'h0), 20'h00111, 4'b0011, "R10 pre-fill");
      cyc(0, '0, 1, 1, mkva(18'h3c4, 2'd0, 12'h0), 20'h00222, 4'b0101, "R10 flush fill");
      look(mkva(18'h3c4, 2'd0, 12'h010), "R10 dropped fill");
      expect_hit(0, "R10 fill discarded");
      look(mkva(18'h3c3, 2'd1, 12'h011), "R10 flushed entry");
      expect_hit(0, "R10 older entry flushed");

      // R6: refill after flush uses empty ways again
      fill(mkva(18'h3c4, 2'd0, 12'h0), 20'h00333, 4'b1111, "R6 refill");
      look(mkva(18'h3c4, 2'd0, 12'hffe), "R6 refill hits");
      expect_hit(1, "R6 refilled entry");

      done = 1;
      summary();
      $finish;
   end
endmodule